// File: doc/BRIEF.md
# Anonymous Interrupt Arbiter with Two-Word Cause Relay

This block sits between a group of I/O units and a processor. Each unit raises its own request line. The block merges the eligible requests into a single interrupt line toward the processor. That line says that some unit wants service, but not which one. The processor samples the line at the end of an instruction and answers with an acknowledge. At that moment the block picks one requester by fixed priority, lowest index first, and sends a one-cycle acknowledge to that unit alone.

Identity and cause then reach the processor as a short message on a shared I/O word bus that uses valid/ready. The selected unit first sends an event identifier and then a parameter. The block passes each word through to the processor-side port, with a flag that marks the parameter word. The block offers no new interrupt until the processor has accepted the parameter.

The processor controls a per-unit mask and a global enable through a single configuration write strobe. At reset every unit is unmasked and the global enable is off.

Top module: `intr_arbiter`

## Requirements
- R1: After reset, cpuIrq, every unitAck bit, cpuValid, busReady and cpuIsParam are 0, cpuWord is 0, the mask is all zeros and the global enable is off.
- R2: While no message is in progress, cpuIrq is 1 exactly when the global enable is on and at least one unit has its request high and its mask bit 0. cpuIrq is combinational in unitReq.
- R3: A unit whose mask bit is 1 can neither raise cpuIrq nor win arbitration.
- R4: With the global enable off, cpuIrq stays 0 and cpuAck has no effect. A cfgWe pulse loads cfgMask and cfgEnable at the next clock edge.
- R5: Suppose cpuAck is high at a clock edge while cpuIrq is 1. In the following cycle, exactly one unitAck bit is high for one cycle: the lowest-indexed unit that was requesting and unmasked at that edge.
- R6: A cpuAck at an edge where cpuIrq is 0 changes no output.
- R7: During the identifier phase, cpuValid equals busValid, cpuWord equals busWord, busReady equals cpuReady and cpuIsParam is 0. The phase ends at the first edge where busValid and cpuReady are both 1.
- R8: During the parameter phase the same pass-through applies with cpuIsParam at 1. A transfer in this phase returns the block to idle.
- R9: From the acknowledge edge until the parameter transfer, cpuIrq stays 0 and no further unitAck is produced, whatever the requests and acknowledges do.
- R10: While idle, cpuValid, busReady and cpuIsParam are 0 and cpuWord is 0, even if busValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| unitReq | input | NUM_UNITS | Request line from each I/O unit |
| unitAck | output | NUM_UNITS | One-cycle acknowledge sent to the selected unit |
| cfgWe | input | 1 | Loads cfgMask and cfgEnable |
| cfgMask | input | NUM_UNITS | Mask bits; a 1 blocks that unit |
| cfgEnable | input | 1 | Global interrupt enable |
| busValid | input | 1 | The selected unit is offering a word on the bus |
| busWord | input | WORD_W | Word on the shared I/O bus |
| busReady | output | 1 | The block accepts the bus word |
| cpuIrq | output | 1 | Anonymous interrupt line to the processor |
| cpuAck | input | 1 | Processor acknowledge |
| cpuValid | output | 1 | Word valid toward the processor |
| cpuWord | output | WORD_W | Identifier or parameter word |
| cpuIsParam | output | 1 | 0 for the identifier word, 1 for the parameter word |
| cpuReady | input | 1 | The processor takes the word |

## Verification
The hardest case to reach from the ports is a conflict inside an acknowledge window. Here an acknowledge arrives in the same cycle as a mask or enable write, or while other units raise and drop requests. During the message phases further acknowledges keep arriving. These cases show whether the grant uses the values in force at the acknowledge edge and whether the busy phases really block new rounds. The bench first runs directed sequences for masking, priority and disable. It then drives thousands of cycles of independently random requests, acknowledges, configuration writes and handshake levels. The write rate is set high enough that writes often land inside acknowledge cycles. A behavioural model is compared against every output in every cycle.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_IDENT = 2'd1,
    PH_PARAM = 2'd2
  } phase_e;

  typedef struct packed {
    logic offerIrq;   // idle: interrupt line may be shown
    logic grantFire;  // take the winner and pulse its acknowledge
    logic relayOn;    // a message word is being passed through
    logic paramWord;  // the word in flight is the parameter
  } ctl_strobes_t;

endpackage

// File: rtl/intr_arb_datapath.sv
module intr_arb_datapath
  import intr_arb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobes_t         strobes,
  input  logic [NUM_UNITS-1:0] unitReq,
  input  logic                 cfgWe,
  input  logic [NUM_UNITS-1:0] cfgMask,
  input  logic                 cfgEnable,
  input  logic                 busValid,
  input  logic [WORD_W-1:0]    busWord,
  input  logic                 cpuReady,
  output logic                 anyPending,
  output logic [NUM_UNITS-1:0] unitAck,
  output logic                 busReady,
  output logic                 cpuIrq,
  output logic                 cpuValid,
  output logic [WORD_W-1:0]    cpuWord,
  output logic                 cpuIsParam
);

  logic [NUM_UNITS-1:0] maskReg;
  logic                 enableReg;
  logic [NUM_UNITS-1:0] eligible;
  logic [NUM_UNITS-1:0] winner;
  logic [NUM_UNITS-1:0] ackPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '0;
      enableReg <= 1'b0;
    end else if (cfgWe) begin
      maskReg   <= cfgMask;
      enableReg <= cfgEnable;
    end
  end

  assign eligible   = unitReq & ~maskReg;
  assign anyPending = enableReg && (|eligible);

  // fixed priority: lowest index wins
  always_comb begin
    winner = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPulse <= '0;
    else if (strobes.grantFire) ackPulse <= winner;
    else ackPulse <= '0;
  end

  assign unitAck    = ackPulse;
  assign cpuIrq     = strobes.offerIrq && anyPending;
  assign cpuValid   = strobes.relayOn && busValid;
  assign busReady   = strobes.relayOn && cpuReady;
  assign cpuWord    = strobes.relayOn ? busWord : '0;
  assign cpuIsParam = strobes.paramWord;

endmodule

// File: rtl/intr_arb_control.sv
module intr_arb_control
  import intr_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyPending,
  input  logic         cpuAck,
  input  logic         busValid,
  input  logic         cpuReady,
  output ctl_strobes_t strobes
);

  phase_e phase, phaseNext;
  logic   moved;

  assign moved = busValid && cpuReady;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:  if (anyPending && cpuAck) phaseNext = PH_IDENT;
      PH_IDENT: if (moved) phaseNext = PH_PARAM;
      PH_PARAM: if (moved) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else phase <= phaseNext;
  end

  always_comb begin
    strobes.offerIrq  = (phase == PH_IDLE);
    strobes.grantFire = (phase == PH_IDLE) && anyPending && cpuAck;
    strobes.relayOn   = (phase == PH_IDENT) || (phase == PH_PARAM);
    strobes.paramWord = (phase == PH_PARAM);
  end

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_arb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_UNITS-1:0] unitReq,
  output logic [NUM_UNITS-1:0] unitAck,
  input  logic                 cfgWe,
  input  logic [NUM_UNITS-1:0] cfgMask,
  input  logic                 cfgEnable,
  input  logic                 busValid,
  input  logic [WORD_W-1:0]    busWord,
  output logic                 busReady,
  output logic                 cpuIrq,
  input  logic                 cpuAck,
  output logic                 cpuValid,
  output logic [WORD_W-1:0]    cpuWord,
  output logic                 cpuIsParam,
  input  logic                 cpuReady
);

  ctl_strobes_t strobes;
  logic         anyPending;

  intr_arb_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .anyPending (anyPending),
    .cpuAck     (cpuAck),
    .busValid   (busValid),
    .cpuReady   (cpuReady),
    .strobes    (strobes)
  );

  intr_arb_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .WORD_W    (WORD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .unitReq    (unitReq),
    .cfgWe      (cfgWe),
    .cfgMask    (cfgMask),
    .cfgEnable  (cfgEnable),
    .busValid   (busValid),
    .busWord    (busWord),
    .cpuReady   (cpuReady),
    .anyPending (anyPending),
    .unitAck    (unitAck),
    .busReady   (busReady),
    .cpuIrq     (cpuIrq),
    .cpuValid   (cpuValid),
    .cpuWord    (cpuWord),
    .cpuIsParam (cpuIsParam)
  );

endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk #(
  parameter int NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_UNITS-1:0] unitReq,
  input logic [NUM_UNITS-1:0] unitAck,
  input logic                 cfgWe,
  input logic                 cfgEnable,
  input logic                 busReady,
  input logic                 cpuIrq,
  input logic                 cpuAck,
  input logic                 cpuValid,
  input logic                 cpuReady
);

  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(unitAck));

  p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|unitAck) |=> !(|unitAck));

  p_ack_needs_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|unitAck) |-> $past(cpuAck && cpuIrq));

  p_disable_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgEnable) |=> !cpuIrq);

  p_busy_no_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> !cpuIrq);

  p_ready_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> cpuReady);

  p_idle_no_relay_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (!busReady && !cpuValid));

  p_irq_has_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (|unitReq));

endmodule

bind intr_arbiter intr_arbiter_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .unitReq   (unitReq),
  .unitAck   (unitAck),
  .cfgWe     (cfgWe),
  .cfgEnable (cfgEnable),
  .busReady  (busReady),
  .cpuIrq    (cpuIrq),
  .cpuAck    (cpuAck),
  .cpuValid  (cpuValid),
  .cpuReady  (cpuReady)
);

// File: tb/test_intr_arbiter.sv
`timescale 1ns/1ps
module test_intr_arbiter;
  localparam int N = 4;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] unitReq = '0;
  logic [N-1:0] unitAck;
  logic         cfgWe = 1'b0;
  logic [N-1:0] cfgMask = '0;
  logic         cfgEnable = 1'b0;
  logic         busValid = 1'b0;
  logic [W-1:0] busWord = '0;
  logic         busReady;
  logic         cpuIrq;
  logic         cpuAck = 1'b0;
  logic         cpuValid;
  logic [W-1:0] cpuWord;
  logic         cpuIsParam;
  logic         cpuReady = 1'b0;

  always #4 clk = ~clk;

  intr_arbiter #(.NUM_UNITS(N), .WORD_W(W)) i_intr_arbiter (
    .clk(clk), .rstN(rstN), .unitReq(unitReq), .unitAck(unitAck),
    .cfgWe(cfgWe), .cfgMask(cfgMask), .cfgEnable(cfgEnable),
    .busValid(busValid), .busWord(busWord), .busReady(busReady),
    .cpuIrq(cpuIrq), .cpuAck(cpuAck), .cpuValid(cpuValid),
    .cpuWord(cpuWord), .cpuIsParam(cpuIsParam), .cpuReady(cpuReady)
  );

  // behavioural reference: phase 0 idle, 1 identifier, 2 parameter
  int           mPhase;
  logic [N-1:0] mMask;
  logic         mEn;
  logic [N-1:0] mAck;
  int           compared = 0;
  int           mismatched = 0;

  function automatic logic modelIrq();
    return (mPhase == 0) && mEn && ((unitReq & ~mMask) != '0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase <= 0; mMask <= '0; mEn <= 1'b0; mAck <= '0;
    end else begin
      logic [N-1:0] pick;
      pick = '0;
      for (int i = 0; i < N; i++)
        if (pick == '0 && unitReq[i] && !mMask[i]) pick[i] = 1'b1;
      mAck <= '0;
      if (mPhase == 0 && cpuAck && modelIrq()) begin
        mAck <= pick; mPhase <= 1;
      end else if (mPhase != 0 && busValid && cpuReady) begin
        mPhase <= (mPhase == 1) ? 2 : 0;
      end
      if (cfgWe) begin mMask <= cfgMask; mEn <= cfgEnable; end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 R3 R4 R9 cpuIrq", W'(cpuIrq), W'(modelIrq()));
    chk("R5 R6 unitAck", W'(unitAck), W'(mAck));
    chk("R7 R10 cpuValid", W'(cpuValid), W'((mPhase != 0) && busValid));
    chk("R7 R10 busReady", W'(busReady), W'((mPhase != 0) && cpuReady));
    chk("R7 R10 cpuWord", cpuWord, (mPhase != 0) ? busWord : '0);
    chk("R8 cpuIsParam", W'(cpuIsParam), W'(mPhase == 2));
  endtask

  task automatic step(input logic [N-1:0] rq, input logic ak, input logic bv,
                      input logic [W-1:0] bw, input logic cr, input logic we,
                      input logic [N-1:0] mk, input logic en);
    @(negedge clk);
    unitReq = rq; cpuAck = ak; busValid = bv; busWord = bw; cpuReady = cr;
    cfgWe = we; cfgMask = mk; cfgEnable = en;
    #1 compareAll();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    #1;
    // R1: reset values
    chk("R1 cpuIrq", W'(cpuIrq), '0);
    chk("R1 unitAck", W'(unitAck), '0);
    chk("R1 cpuValid", W'(cpuValid), '0);
    chk("R1 cpuWord", cpuWord, '0);
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // R4: enable off, requests and acknowledge ignored
    step(4'b0001, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    step(4'b0001, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    // R3: mask unit 1, enable
    step(4'b0000, 1'b0, 1'b0, '0, 1'b0, 1'b1, 4'b0010, 1'b1);
    step(4'b0010, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    step(4'b0010, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    // R5: units 1,2,3 request, unit 1 masked, unit 2 wins
    step(4'b1110, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    // R9: during message, acks ignored; R7 stall then identifier
    step(4'b1010, 1'b1, 1'b1, 32'hE1, 1'b0, 1'b0, '0, 1'b0);
    step(4'b1010, 1'b1, 1'b1, 32'hE1, 1'b1, 1'b0, '0, 1'b0);
    // R8: parameter
    step(4'b1010, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, '0, 1'b0);
    step(4'b1010, 1'b0, 1'b1, 32'hAB, 1'b1, 1'b0, '0, 1'b0);
    // R6, R10: idle again, bus noise not relayed; unit 3 served next
    step(4'b1000, 1'b0, 1'b1, 32'h55, 1'b1, 1'b0, '0, 1'b0);
    step(4'b1000, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    step(4'b0000, 1'b0, 1'b1, 32'h7, 1'b1, 1'b0, '0, 1'b0);
    step(4'b0000, 1'b0, 1'b1, 32'h9, 1'b1, 1'b0, '0, 1'b0);
    // R4: disable in the same cycle as an acknowledge
    step(4'b0001, 1'b1, 1'b0, '0, 1'b0, 1'b1, '0, 1'b0);
    step(4'b0001, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    // random soak: R2 R3 R5 R6 R7 R8 R9 R10 against the model
    for (int c = 0; c < 6000; c++) begin
      step(N'($urandom), ($urandom % 3) == 0, $urandom % 2, $urandom,
           $urandom % 2, ($urandom % 8) == 0, N'($urandom), ($urandom % 4) != 0);
    end
    finishRun();
  end
endmodule